// File: doc/BRIEF.md
# Processor Exception Control Unit

This block takes the exception requests raised while one instruction executes and picks one of them. Each cause belongs to one of three classes. A fault is a repairable condition, so the instruction runs again after the handler. A trap asks for a service, so execution goes on with the following instruction. An abort is fatal and stops the core. For an accepted request the unit saves a return address and a cause code, switches to kernel mode and remembers the previous mode. Faults and traps then send fetch to one handler address that is fixed at build time.

A one-cycle return strobe from the handler sends fetch back to the saved return address and restores the saved mode. An abort sets a sticky halt flag and does not redirect fetch. After that, the unit ignores all requests, return strobes and mode writes until reset.

Top module: `exc_ctrl_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `epc` and `cause` read 0, `halted` reads 0, `mode_user` reads 0 (kernel) and `pc_redirect_valid` reads 0.
- R2: Bit i of `exc_req` requests cause code i. Codes 1 (divide by zero), 2 (misaligned), 3 (page fault), 4 (reserved opcode) and 5 (privilege violation) are faults. Codes 0 (overflow), 6 (system call) and 7 (breakpoint) are traps. Code 8 (parity error) is an abort.
- R3: When a fault is accepted, the outputs after the next rising edge show `epc` equal to the `cur_pc` of the request cycle, `cause` equal to the fault's code, `pc_redirect_valid` at 1 and `pc_redirect` equal to `HANDLER_VEC`.
- R4: When a trap is accepted, `epc` becomes the request cycle's `cur_pc` plus 4, `cause` becomes the trap's code, and fetch is redirected to `HANDLER_VEC`.
- R5: When an abort is accepted, `halted` becomes 1, `cause` becomes 8, `epc` becomes `cur_pc`, and `pc_redirect_valid` stays 0.
- R6: When several bits of `exc_req` are set, an abort wins over any fault and a fault wins over any trap. Within a class, the lowest code wins.
- R7: Any accepted exception sets `mode_user` to 0 and saves the mode that was in force before it.
- R8: A `ret_strobe` with no request pending gives `pc_redirect_valid` = 1 and `pc_redirect` = the current `epc` after the next edge, and `mode_user` returns to the saved mode.
- R9: While `halted` is 1, requests, `ret_strobe` and mode writes change none of `epc`, `cause`, `mode_user` or `halted`, and `pc_redirect_valid` stays 0. Only reset clears `halted`.
- R10: A request in the same cycle as `ret_strobe` or `mode_we` is taken as an exception, and the strobe and the write are dropped.
- R11: `mode_we` with no request and no return loads `mode_user_in` into `mode_user` (1 = user).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | XLEN | Address of the instruction now executing |
| exc_req | input | 9 | Per-cause request flags; bit i is cause code i |
| ret_strobe | input | 1 | Handler return, one cycle |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_user_in | input | 1 | Mode value to write, 1 = user |
| pc_redirect_valid | output | 1 | Fetch must load `pc_redirect` this cycle |
| pc_redirect | output | XLEN | Target fetch address |
| epc | output | XLEN | Saved return address |
| cause | output | 4 | Saved cause code |
| halted | output | 1 | Sticky abort flag |
| mode_user | output | 1 | Current mode, 1 = user, 0 = kernel |

## Verification
A new exception and a handler return can both arrive in the same cycle, and so can an exception and a mode write. The bench raises a system call while `ret_strobe` and `mode_we` are high. It passes only if fetch goes to the handler vector, the saved address is the trap's next instruction, and the mode is kernel. A following plain return must then come back to that saved address. The bench also sweeps all 255 combinations of the eight non-abort request bits. Each result is compared with the winner the bench works out from the class order.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int CAUSE_W    = 4;
    localparam int NUM_CAUSES = 9;
    localparam int INSN_BYTES = 4;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_FAULT = 2'd1,
        CLS_TRAP  = 2'd2,
        CLS_ABORT = 2'd3
    } exc_class_e;

    typedef enum logic [CAUSE_W-1:0] {
        C_OVF      = 4'd0,
        C_DIV0     = 4'd1,
        C_MISALIGN = 4'd2,
        C_PGFAULT  = 4'd3,
        C_RSVD_OP  = 4'd4,
        C_PRIV     = 4'd5,
        C_SYSCALL  = 4'd6,
        C_BRKPT    = 4'd7,
        C_PARITY   = 4'd8
    } cause_e;

    typedef struct packed {
        logic               valid;
        exc_class_e         cls;
        logic [CAUSE_W-1:0] code;
    } exc_pick_t;

    function automatic exc_class_e class_of(input int unsigned code);
        case (code)
            0, 6, 7:       return CLS_TRAP;
            1, 2, 3, 4, 5: return CLS_FAULT;
            8:             return CLS_ABORT;
            default:       return CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/exc_prioritizer.sv
module exc_prioritizer
    import exc_pkg::*;
#(
    parameter int N = NUM_CAUSES
) (
    input  logic [N-1:0] req,
    output exc_pick_t    pick
);

    logic [N-1:0] is_fault;
    logic [N-1:0] is_trap;
    logic [N-1:0] is_abort;

    for (genvar gi = 0; gi < N; gi++) begin : g_cls
        assign is_fault[gi] = (class_of(gi) == CLS_FAULT);
        assign is_trap[gi]  = (class_of(gi) == CLS_TRAP);
        assign is_abort[gi] = (class_of(gi) == CLS_ABORT);
    end

    logic [N-1:0] fault_req, trap_req, abort_req;
    assign fault_req = req & is_fault;
    assign trap_req  = req & is_trap;
    assign abort_req = req & is_abort;

    always_comb begin
        pick       = '0;
        pick.cls   = CLS_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (trap_req[i]) begin
                pick.valid = 1'b1;
                pick.cls   = CLS_TRAP;
                pick.code  = CAUSE_W'(i);
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (fault_req[i]) begin
                pick.valid = 1'b1;
                pick.cls   = CLS_FAULT;
                pick.code  = CAUSE_W'(i);
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (abort_req[i]) begin
                pick.valid = 1'b1;
                pick.cls   = CLS_ABORT;
                pick.code  = CAUSE_W'(i);
            end
        end
    end

endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  exc_class_e      cls,
    output logic [XLEN-1:0] ret_addr
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        if (cls == CLS_TRAP) ret_addr = pc + STEP;
        else                 ret_addr = pc;
    end

endmodule

// File: rtl/exc_mode_track.sv
module exc_mode_track (
    input  logic clk,
    input  logic rst,
    input  logic take_exc,
    input  logic do_ret,
    input  logic wr_en,
    input  logic wr_val,
    output logic mode_user,
    output logic saved_user
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_user  <= 1'b0;
            saved_user <= 1'b0;
        end else if (take_exc) begin
            saved_user <= mode_user;
            mode_user  <= 1'b0;
        end else if (do_ret) begin
            mode_user  <= saved_user;
        end else if (wr_en) begin
            mode_user  <= wr_val;
        end
    end

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int unsigned HANDLER_VEC = 32'h0000_0100
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [XLEN-1:0]       cur_pc,
    input  logic [NUM_CAUSES-1:0] exc_req,
    input  logic                  ret_strobe,
    input  logic                  mode_we,
    input  logic                  mode_user_in,
    output logic                  pc_redirect_valid,
    output logic [XLEN-1:0]       pc_redirect,
    output logic [XLEN-1:0]       epc,
    output logic [CAUSE_W-1:0]    cause,
    output logic                  halted,
    output logic                  mode_user
);

    localparam logic [XLEN-1:0] VEC = XLEN'(HANDLER_VEC);

    exc_pick_t       pick;
    logic [XLEN-1:0] ret_addr;
    logic            take_exc, do_ret, mode_wr;
    logic            saved_user;

    exc_prioritizer #(.N(NUM_CAUSES)) u_prio (
        .req  (exc_req),
        .pick (pick)
    );

    exc_ret_addr #(.XLEN(XLEN)) u_ret (
        .pc       (cur_pc),
        .cls      (pick.cls),
        .ret_addr (ret_addr)
    );

    assign take_exc = pick.valid && !halted;
    assign do_ret   = ret_strobe && !halted && !pick.valid;
    assign mode_wr  = mode_we && !halted && !pick.valid && !ret_strobe;

    exc_mode_track u_mode (
        .clk        (clk),
        .rst        (rst),
        .take_exc   (take_exc),
        .do_ret     (do_ret),
        .wr_en      (mode_wr),
        .wr_val     (mode_user_in),
        .mode_user  (mode_user),
        .saved_user (saved_user)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            epc               <= '0;
            cause             <= '0;
            halted            <= 1'b0;
            pc_redirect_valid <= 1'b0;
            pc_redirect       <= '0;
        end else if (take_exc) begin
            epc   <= ret_addr;
            cause <= pick.code;
            if (pick.cls == CLS_ABORT) begin
                halted            <= 1'b1;
                pc_redirect_valid <= 1'b0;
            end else begin
                pc_redirect_valid <= 1'b1;
                pc_redirect       <= VEC;
            end
        end else if (do_ret) begin
            pc_redirect_valid <= 1'b1;
            pc_redirect       <= epc;
        end else begin
            pc_redirect_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/exc_ctrl_checker.sv
module exc_ctrl_checker
    import exc_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int unsigned HANDLER_VEC = 32'h0000_0100
) (
    input logic                  clk,
    input logic                  rst,
    input logic [XLEN-1:0]       cur_pc,
    input logic [NUM_CAUSES-1:0] exc_req,
    input logic                  ret_strobe,
    input logic                  mode_we,
    input logic                  mode_user_in,
    input logic                  pc_redirect_valid,
    input logic [XLEN-1:0]       pc_redirect,
    input logic [XLEN-1:0]       epc,
    input logic [CAUSE_W-1:0]    cause,
    input logic                  halted,
    input logic                  mode_user
);

    localparam logic [XLEN-1:0] VEC  = XLEN'(HANDLER_VEC);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_no_redirect_R5: assert property (@(posedge clk) disable iff (rst)
        halted |-> !pc_redirect_valid);

    assert_abort_halts_R5: assert property (@(posedge clk) disable iff (rst)
        (!halted && exc_req[8]) |=> (halted && cause == 4'd8));

    assert_exc_kernel_R7: assert property (@(posedge clk) disable iff (rst)
        (!halted && |exc_req) |=> !mode_user);

    assert_trap_next_R4: assert property (@(posedge clk) disable iff (rst)
        (!halted && exc_req == 9'b0_0100_0000)
        |=> (epc == $past(cur_pc) + STEP && cause == 4'd6 && pc_redirect == VEC));

    assert_fault_same_R3: assert property (@(posedge clk) disable iff (rst)
        (!halted && exc_req == 9'b0_0000_1000)
        |=> (epc == $past(cur_pc) && cause == 4'd3 && pc_redirect_valid));

    assert_return_epc_R8: assert property (@(posedge clk) disable iff (rst)
        (!halted && exc_req == '0 && ret_strobe)
        |=> (pc_redirect_valid && pc_redirect == $past(epc)));

    assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(epc) && $stable(cause) && $stable(mode_user)));

endmodule

bind exc_ctrl_unit exc_ctrl_checker #(
    .XLEN        (XLEN),
    .HANDLER_VEC (HANDLER_VEC)
) u_exc_chk (
    .clk               (clk),
    .rst               (rst),
    .cur_pc            (cur_pc),
    .exc_req           (exc_req),
    .ret_strobe        (ret_strobe),
    .mode_we           (mode_we),
    .mode_user_in      (mode_user_in),
    .pc_redirect_valid (pc_redirect_valid),
    .pc_redirect       (pc_redirect),
    .epc               (epc),
    .cause             (cause),
    .halted            (halted),
    .mode_user         (mode_user)
);

// File: tb/exc_ctrl_unit_tb.sv
module exc_ctrl_unit_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          XLEN       = 32;
    localparam int unsigned VEC        = 32'h0000_0100;
    localparam int          WDOG       = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [XLEN-1:0]  cur_pc = '0;
    logic [8:0]       exc_req = '0;
    logic             ret_strobe = 1'b0;
    logic             mode_we = 1'b0;
    logic             mode_user_in = 1'b0;
    logic             pc_redirect_valid;
    logic [XLEN-1:0]  pc_redirect;
    logic [XLEN-1:0]  epc;
    logic [3:0]       cause;
    logic             halted;
    logic             mode_user;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_ctrl_unit #(.XLEN(XLEN), .HANDLER_VEC(VEC)) dut_i (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .exc_req(exc_req),
        .ret_strobe(ret_strobe), .mode_we(mode_we), .mode_user_in(mode_user_in),
        .pc_redirect_valid(pc_redirect_valid), .pc_redirect(pc_redirect),
        .epc(epc), .cause(cause), .halted(halted), .mode_user(mode_user)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at falling edge, let one rising edge pass, sample 1 time unit later
    task automatic step(input logic [8:0] req, input logic ret, input logic we,
                        input logic wv, input logic [XLEN-1:0] pc);
        @(negedge clk);
        exc_req = req; ret_strobe = ret; mode_we = we; mode_user_in = wv; cur_pc = pc;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; exc_req = '0; ret_strobe = 1'b0; mode_we = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        check("R1", "epc in reset", epc, 0);
        check("R1", "halted in reset", 32'(halted), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int expected_code(input logic [8:0] r);
        if (r[8]) return 8;
        for (int c = 1; c <= 5; c++) if (r[c]) return c;
        if (r[0]) return 0;
        if (r[6]) return 6;
        if (r[7]) return 7;
        return -1;
    endfunction

    initial begin
        do_reset();
        step(9'd0, 0, 0, 0, 32'h0);
        check("R1", "epc", epc, 0);
        check("R1", "cause", 32'(cause), 0);
        check("R1", "halted", 32'(halted), 0);
        check("R1", "mode_user", 32'(mode_user), 0);
        check("R1", "redirect_valid", 32'(pc_redirect_valid), 0);

        // R6/R3/R4/R7/R8/R2 sweep over every non-abort request pattern
        for (int p = 1; p < 256; p++) begin
            logic [XLEN-1:0] pc;
            int code;
            logic [XLEN-1:0] exp_epc;
            pc   = 32'h0000_4000 + 32'(p) * 8;
            code = expected_code(9'(p));
            exp_epc = (code == 0 || code == 6 || code == 7) ? pc + 4 : pc;
            step(9'd0, 0, 1, 1, pc);
            check("R11", "mode write user", 32'(mode_user), 1);
            step(9'(p), 0, 0, 0, pc);
            check("R6", "cause pick", 32'(cause), 32'(code));
            check((exp_epc == pc) ? "R3" : "R4", "epc", epc, exp_epc);
            check("R2", "redirect valid", 32'(pc_redirect_valid), 1);
            check("R2", "redirect vector", pc_redirect, VEC);
            check("R7", "mode kernel", 32'(mode_user), 0);
            step(9'd0, 1, 0, 0, pc);
            check("R8", "return valid", 32'(pc_redirect_valid), 1);
            check("R8", "return target", pc_redirect, exp_epc);
            check("R8", "mode restored", 32'(mode_user), 1);
            step(9'd0, 0, 0, 0, pc);
            check("R8", "redirect one cycle", 32'(pc_redirect_valid), 0);
        end

        // R7: exception from kernel saves kernel
        step(9'd0, 0, 1, 0, 32'h100);
        step(9'b0_1000_0000, 0, 0, 0, 32'h200);
        step(9'd0, 1, 0, 0, 32'h200);
        check("R7", "kernel saved/restored", 32'(mode_user), 0);
        check("R8", "breakpoint return", pc_redirect, 32'h204);

        // R10: exception with return strobe and mode write in same cycle
        step(9'd0, 0, 1, 1, 32'h300);
        step(9'b0_0100_0000, 1, 1, 1, 32'h800);
        check("R10", "redirect to vector", pc_redirect, VEC);
        check("R10", "epc trap", epc, 32'h804);
        check("R10", "mode kernel", 32'(mode_user), 0);
        step(9'd0, 1, 0, 0, 32'h800);
        check("R10", "later return", pc_redirect, 32'h804);
        check("R10", "mode back to user", 32'(mode_user), 1);

        // R5/R9: abort alone and combined with each other cause
        for (int k = -1; k < 8; k++) begin
            logic [8:0] r;
            r = 9'h100 | ((k >= 0) ? (9'd1 << k) : 9'd0);
            do_reset();
            step(9'd0, 0, 1, 1, 32'h10);
            step(r, 0, 0, 0, 32'h0000_9000);
            check("R5", "halted", 32'(halted), 1);
            check("R5", "cause", 32'(cause), 8);
            check("R5", "epc", epc, 32'h0000_9000);
            check("R5", "no redirect", 32'(pc_redirect_valid), 0);
            step(9'b0_0100_0010, 1, 1, 1, 32'h0000_A000);
            check("R9", "halted kept", 32'(halted), 1);
            check("R9", "cause kept", 32'(cause), 8);
            check("R9", "epc kept", epc, 32'h0000_9000);
            check("R9", "mode kept", 32'(mode_user), 0);
            check("R9", "no redirect", 32'(pc_redirect_valid), 0);
            step(9'd0, 1, 0, 0, 32'h0);
            check("R9", "return ignored", 32'(pc_redirect_valid), 0);
        end
        do_reset();
        step(9'd0, 0, 0, 0, 32'h0);
        check("R9", "reset clears halt", 32'(halted), 0);
        check("R1", "cause after reset", 32'(cause), 0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule